// File: doc/BRIEF.md
# Page Program Buffer

This block sits behind a serial command decoder in a small non-volatile storage model. The decoder hands it a start address, then a stream of data bytes, then a frame-end pulse. The block collects the bytes in a one-page latch of sixteen entries and keeps a valid bit for each entry. When the frame closes cleanly on a byte boundary and writes are permitted, it runs a timed programming cycle. At the end of that cycle it copies the loaded entries into a 512 x 8 register array.

The write pointer never leaves the page named by the start address. After the last slot of a page, the next byte goes back to the first slot and overwrites what was latched there. The programming cycle cannot be cancelled once it has started. Its length, counted in system clocks, comes from an input so that a simulation can use a short value. The array has a registered read port. The port refuses requests while a cycle runs, and a one-cycle completion pulse tells the protection logic to clear its write enable.

Top module: `page_program_buffer`

## Requirements
- R1: After synchronous reset, `busy`, `done` and `rd_valid` are 0, and every array location reads as 0.
- R2: `addr_load` sets the page (`addr_in[8:4]`) and the slot (`addr_in[3:0]`). Each `byte_load` latches `byte_in` at the current slot and then advances the slot by one modulo 16 inside the same page. A later byte that lands on an already loaded slot replaces the earlier one.
- R3: A cycle starts only when `frame_end` is seen with `frame_whole` = 1, `write_ok` = 1 and at least one byte loaded. In every other case the latch is emptied, nothing is written and `busy` stays 0.
- R4: `busy` rises in the cycle after the accepted `frame_end` and stays 1 for exactly max(`prog_len`, 1) cycles.
- R5: `done` is a single-cycle pulse in the first cycle with `busy` back at 0. A read issued in that cycle already returns the new contents.
- R6: When `busy` = 0, `rd_en` returns the byte at `rd_addr` on `rd_data`, with `rd_valid` = 1, in the next cycle. When `busy` = 1, the request is dropped and `rd_valid` is 0 in the next cycle.
- R7: A commit writes only the slots loaded in that frame. The other slots of the page and all other pages keep their contents.
- R8: When `write_ok` is 0 at `frame_end`, the frame is discarded and no busy period follows.
- R9: While `busy` = 1, `addr_load`, `byte_load`, `frame_end` and changes of `write_ok` have no effect. The running cycle completes with the data it started with, and no second cycle follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_load | input | 1 | Strobe: take start address |
| addr_in | input | 9 | Start address (page in [8:4], slot in [3:0]) |
| byte_load | input | 1 | Strobe: latch one data byte |
| byte_in | input | 8 | Data byte |
| frame_end | input | 1 | Pulse: frame closed |
| frame_whole | input | 1 | Frame ended right after a full byte |
| write_ok | input | 1 | Write permission, sampled at frame end |
| prog_len | input | 20 | Programming time in clocks (0 acts as 1) |
| rd_en | input | 1 | Array read request |
| rd_addr | input | 9 | Array read address |
| busy | output | 1 | Programming cycle in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_valid | output | 1 | Read data returned this cycle |
| rd_data | output | 8 | Read data |

## Verification
The bench sweeps every start slot against frame lengths of 1 to 17 bytes. This covers the wrap at slot 15, where a design that carried into the next page would corrupt a neighbouring page and leave the wrapped slots stale. Frames that end mid-byte, carry no byte at all, or arrive without permission must leave the array and `busy` untouched. A design that committed them anyway would show a stray busy period or changed bytes. Traffic injected during a long cycle, including a write-permission drop and a second frame, checks that the cycle is neither restarted, aborted nor merged with new data. A zero programming length checks the lower bound of the busy window.

// File: rtl/pce_pkg.sv
package pce_pkg;
    localparam int ADDR_W = 9;
    localparam int SLOT_W = 4;
    localparam int DATA_W = 8;
    localparam int TIME_W = 20;
    localparam int PAGE_W = ADDR_W - SLOT_W;
    localparam int SLOTS  = 1 << SLOT_W;
    localparam int PAGES  = 1 << PAGE_W;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] dat;
    } slot_t;

    typedef enum logic {T_IDLE, T_PROG} tstate_e;

    function automatic logic [SLOT_W-1:0] next_slot(input logic [SLOT_W-1:0] s);
        return s + 1'b1;
    endfunction

    function automatic logic [TIME_W-1:0] first_count(input logic [TIME_W-1:0] len);
        return (len == '0) ? '0 : len - 1'b1;
    endfunction
endpackage

// File: rtl/pce_latch.sv
module pce_latch
    import pce_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  hold,
    input  logic                  discard,
    input  logic                  addr_load,
    input  logic [ADDR_W-1:0]     addr_in,
    input  logic                  byte_load,
    input  logic [DATA_W-1:0]     byte_in,
    output logic [PAGE_W-1:0]     page,
    output slot_t [SLOTS-1:0]     slots,
    output logic                  any_valid
);
    logic [SLOT_W-1:0] ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            page  <= '0;
            ptr   <= '0;
            slots <= '0;
        end else if (discard) begin
            for (int s = 0; s < SLOTS; s++) slots[s].vld <= 1'b0;
        end else if (!hold) begin
            if (addr_load) begin
                page <= addr_in[ADDR_W-1:SLOT_W];
                ptr  <= addr_in[SLOT_W-1:0];
                for (int s = 0; s < SLOTS; s++) slots[s].vld <= 1'b0;
            end else if (byte_load) begin
                slots[ptr] <= '{vld: 1'b1, dat: byte_in};
                ptr        <= next_slot(ptr);
            end
        end
    end

    always_comb begin
        any_valid = 1'b0;
        for (int s = 0; s < SLOTS; s++) any_valid = any_valid | slots[s].vld;
    end
endmodule

// File: rtl/pce_timer.sv
module pce_timer
    import pce_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [TIME_W-1:0] prog_len,
    output logic              busy,
    output logic              finish,
    output logic              done
);
    tstate_e           st;
    logic [TIME_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= T_IDLE;
            cnt  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                T_IDLE: if (start) begin
                    st  <= T_PROG;
                    cnt <= first_count(prog_len);
                end
                T_PROG: if (cnt == '0) begin
                    st   <= T_IDLE;
                    done <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                default: st <= T_IDLE;
            endcase
        end
    end

    assign busy   = (st == T_PROG);
    assign finish = busy && (cnt == '0);
endmodule

// File: rtl/pce_array.sv
module pce_array
    import pce_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic [PAGE_W-1:0] page,
    input  slot_t [SLOTS-1:0] slots,
    input  logic              rd_en,
    input  logic              rd_block,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    logic [SLOTS-1:0][DATA_W-1:0] lane_q;

    for (genvar g = 0; g < SLOTS; g++) begin : g_bank
        logic [DATA_W-1:0] bank [PAGES];
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int p = 0; p < PAGES; p++) bank[p] <= '0;
            end else if (commit && slots[g].vld) begin
                bank[page] <= slots[g].dat;
            end
        end
        assign lane_q[g] = bank[rd_addr[ADDR_W-1:SLOT_W]];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en && !rd_block;
            if (rd_en && !rd_block) rd_data <= lane_q[rd_addr[SLOT_W-1:0]];
        end
    end
endmodule

// File: rtl/page_program_buffer.sv
module page_program_buffer
    import pce_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              byte_load,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              frame_end,
    input  logic              frame_whole,
    input  logic              write_ok,
    input  logic [TIME_W-1:0] prog_len,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              busy,
    output logic              done,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    logic              start, finish, discard, any_valid;
    logic [PAGE_W-1:0] page;
    slot_t [SLOTS-1:0] slots;

    assign start   = frame_end && !busy && frame_whole && write_ok && any_valid;
    assign discard = (frame_end && !busy && !start) || finish;

    pce_latch u_latch (
        .clk(clk), .rst(rst), .hold(busy), .discard(discard),
        .addr_load(addr_load), .addr_in(addr_in),
        .byte_load(byte_load), .byte_in(byte_in),
        .page(page), .slots(slots), .any_valid(any_valid)
    );

    pce_timer u_timer (
        .clk(clk), .rst(rst), .start(start), .prog_len(prog_len),
        .busy(busy), .finish(finish), .done(done)
    );

    pce_array u_array (
        .clk(clk), .rst(rst), .commit(finish), .page(page), .slots(slots),
        .rd_en(rd_en), .rd_block(busy), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );
endmodule

// File: rtl/pce_checker.sv
module pce_checker
    import pce_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              frame_end,
    input logic              frame_whole,
    input logic              write_ok,
    input logic [TIME_W-1:0] prog_len,
    input logic              rd_en,
    input logic              busy,
    input logic              done,
    input logic              rd_valid
);
    logic [TIME_W-1:0] run_len, exp_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= '0;
            exp_len <= '0;
        end else begin
            run_len <= busy ? run_len + 1'b1 : '0;
            if (!busy) exp_len <= (prog_len == '0) ? TIME_W'(1) : prog_len;
        end
    end

    AST_START_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(frame_end && frame_whole && write_ok)); // R3
    AST_BUSY_LEN: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> run_len == exp_len); // R4
    AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done); // R5
    AST_DONE_ONLY_AT_FALL: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy))); // R5
    AST_READ_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        busy |=> !rd_valid); // R6
    AST_READ_SERVED: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !busy) |=> rd_valid); // R6
endmodule

bind page_program_buffer pce_checker u_chk (
    .clk(clk), .rst(rst), .frame_end(frame_end), .frame_whole(frame_whole),
    .write_ok(write_ok), .prog_len(prog_len), .rd_en(rd_en),
    .busy(busy), .done(done), .rd_valid(rd_valid)
);

// File: tb/test_page_program_buffer.sv
module test_page_program_buffer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        addr_load = 0, byte_load = 0, frame_end = 0, frame_whole = 0;
    logic        write_ok = 1, rd_en = 0;
    logic [8:0]  addr_in = '0, rd_addr = '0;
    logic [7:0]  byte_in = '0;
    logic [19:0] prog_len = 20'd5;
    logic        busy, done, rd_valid;
    logic [7:0]  rd_data;

    int checks = 0, errors = 0;
    logic [7:0] model [512];
    logic [4:0] bpage;
    logic [3:0] bslot;
    logic [7:0] bdat [16];
    logic [15:0] bvld;

    always #10 clk = ~clk;

    page_program_buffer i_page_program_buffer (
        .clk(clk), .rst(rst), .addr_load(addr_load), .addr_in(addr_in),
        .byte_load(byte_load), .byte_in(byte_in), .frame_end(frame_end),
        .frame_whole(frame_whole), .write_ok(write_ok), .prog_len(prog_len),
        .rd_en(rd_en), .rd_addr(rd_addr), .busy(busy), .done(done),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drive_load(input logic [8:0] a);
        @(negedge clk); addr_load = 1; addr_in = a;
        @(negedge clk); addr_load = 0;
    endtask
    task automatic drive_byte(input logic [7:0] b);
        @(negedge clk); byte_load = 1; byte_in = b;
        @(negedge clk); byte_load = 0;
    endtask
    task automatic drive_end(input logic w);
        @(negedge clk); frame_end = 1; frame_whole = w;
        @(negedge clk); frame_end = 0; frame_whole = 0;
    endtask

    task automatic b_frame(input logic [8:0] a);
        bpage = a[8:4]; bslot = a[3:0]; bvld = '0;
        drive_load(a);
    endtask
    task automatic b_byte(input logic [7:0] d);
        bdat[bslot] = d; bvld[bslot] = 1'b1; bslot = bslot + 1'b1;
        drive_byte(d);
    endtask
    task automatic b_apply();
        for (int s = 0; s < 16; s++) if (bvld[s]) model[{bpage, 4'(s)}] = bdat[s];
    endtask

    task automatic rd(input logic [8:0] a, output logic [7:0] d, output logic v);
        @(negedge clk); rd_en = 1; rd_addr = a;
        @(negedge clk); d = rd_data; v = rd_valid; rd_en = 0;
    endtask

    task automatic verify(input logic [8:0] a, input string tag);
        logic [7:0] d; logic v;
        rd(a, d, v);
        check(v === 1'b1 && d === model[a], tag, int'(d), int'(model[a]));
    endtask
    task automatic verify_page(input logic [4:0] p, input string tag);
        for (int s = 0; s < 16; s++) verify({p, 4'(s)}, tag);
    endtask

    // After drive_end of an accepted frame: count the busy window, then done.
    task automatic expect_commit(input string tag);
        int n = 0;
        int want = (prog_len == 0) ? 1 : int'(prog_len);
        while (busy === 1'b1) begin n++; @(negedge clk); end
        check(n == want, {tag, " R4 busy length"}, n, want);
        check(done === 1'b1, {tag, " R5 done at end"}, int'(done), 1);
        @(negedge clk);
        check(done === 1'b0, "R5 done single cycle", int'(done), 0);
        b_apply();
    endtask

    task automatic expect_idle(input string tag);
        bit ok = 1;
        repeat (8) begin
            @(negedge clk);
            if (busy !== 1'b0 || done !== 1'b0) ok = 0;
        end
        check(ok, tag, int'(busy), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d; logic v;
        for (int i = 0; i < 512; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check(busy === 0 && done === 0 && rd_valid === 0, "R1 outputs after reset", int'(busy), 0);
        verify(9'h000, "R1 array zero");
        verify(9'h1FF, "R1 array zero");
        verify(9'h100, "R1 array zero");

        // R2 single byte, R4/R5 timing
        b_frame(9'h1F3); b_byte(8'hA5); drive_end(1);
        check(busy === 1'b1, "R4 busy after frame end", int'(busy), 1);
        expect_commit("single");
        verify(9'h1F3, "R2 single byte");
        verify(9'h1F4, "R7 neighbour untouched");

        // R3 frame ending mid-byte
        b_frame(9'h040); b_byte(8'h11); b_byte(8'h22); drive_end(0);
        expect_idle("R3 partial byte no cycle");
        verify(9'h040, "R3 nothing written"); verify(9'h041, "R3 nothing written");

        // R3 zero-byte frame
        b_frame(9'h050); drive_end(1);
        expect_idle("R3 empty frame no cycle");

        // R8 no permission
        write_ok = 0;
        b_frame(9'h060); b_byte(8'h33); drive_end(1);
        expect_idle("R8 denied no cycle");
        verify(9'h060, "R8 nothing written");
        write_ok = 1;

        // R2 / R7 sweep over start slot and frame length
        for (int s = 0; s < 16; s++) begin
            for (int n = 1; n <= 17; n++) begin
                logic [4:0] p = 5'((s * 7 + n) % 32);
                b_frame({p, 4'(s)});
                for (int k = 0; k < n; k++) b_byte(8'((s * 31 + n * 17 + k * 5 + 1) & 255));
                drive_end(1);
                expect_commit("sweep");
                verify_page(p, "R2 R7 sweep page");
            end
        end

        // R9 with a long cycle, R6 reads blocked while busy
        prog_len = 20'd12;
        b_frame(9'h03E);
        for (int k = 0; k < 4; k++) b_byte(8'(8'hC0 + k));
        drive_end(1);
        write_ok = 0;
        drive_load(9'h1E0); drive_byte(8'h55); drive_end(1);
        rd(9'h03E, d, v);
        check(v === 1'b0, "R6 read ignored while busy", int'(v), 0);
        write_ok = 1;
        while (busy === 1'b1) @(negedge clk);
        check(done === 1'b1, "R9 cycle completed", int'(done), 1);
        b_apply();
        expect_idle("R9 no second cycle");
        verify_page(5'h03, "R9 data of running cycle");
        verify_page(5'h1E, "R9 late frame ignored");

        // R4 zero length acts as one
        prog_len = 20'd0;
        b_frame(9'h0A2); b_byte(8'h5A); drive_end(1);
        expect_commit("zero length");
        verify(9'h0A2, "R2 zero length write");
        prog_len = 20'd5;

        // R7 full array compare
        for (int i = 0; i < 512; i++) verify(9'(i), "R7 full array");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule